// File: doc/BRIEF.md
# Display Auxiliary Channel Transaction Sequencer

This block carries out one auxiliary-channel transaction for a host. It also repeats that transaction when the sink asks it to wait. A host hands it a command: a 4-bit request type, an address, a byte count from 1 to 16, up to 16 bytes of write data and a flag that permits repeats. The sequencer then takes the following steps in order:

- It waits for the channel engine below it to go quiet.
- It claims the channel through a request/acknowledge pair.
- It confirms that a sink is attached.
- It loads the command word, the address and the transmit buffer.
- It issues the transfer and sorts the reply into a final outcome.

Every attempt opens with a one-cycle engine reset pulse. Every attempt after the first then waits for a fixed back-off before it raises the request. Wire-level encoding is handled by the engine, not here.

All waits are counted in microseconds from a divided clock. The 1 ms limits and the 400 µs back-off therefore shrink together when `CLK_PER_US` or the interval parameters are lowered.

The command side is a valid/ready stream:
- A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- `cmd_ready` is high only while the block is idle.
- The command fields must stay stable while `cmd_valid` waits for `cmd_ready`.

The result side has no back-pressure. `done` is a one-cycle pulse, and the result fields are valid with it. They hold their values until the next command is accepted.

Top module: `aux_retry_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `done`, `own_req`, `eng_req` and `eng_rst` are all 0. `cmd_ready` stays low from the cycle after a command is accepted until that command's `done`.
- R2: Before claiming the channel, the block waits until `eng_busy` is 0 and `own_ack` is 2'b00. If that does not happen within `IDLE_US` microseconds, it finishes with result code 1 (busy) and never raises `own_req`.
- R3: The block claims the channel by raising `own_req` bit `OWN_SEL` alone. It proceeds only when `own_ack` equals exactly that one-hot value. Any other value, held for `OWN_US` microseconds, ends the command with code 1 and releases `own_req`.
- R4: If `eng_sink` is 0 once the channel is owned, the block finishes with code 2 (no device) and never raises `eng_req`.
- R5: A write-type command (type bit 0 = 0) loads `eng_wdata` before the first attempt. Byte k of `cmd_wdata` (bits 8k+7:8k) goes to the same position for k < length, and the higher bytes are 0. A read-type command (type bit 0 = 1) leaves `eng_wdata` unchanged.
- R6: `eng_cmd` carries the request type in bits 15:12 and the byte count minus one in bits 7:0. All its other bits are 0. `eng_addr` carries the command address.
- R7: Each attempt starts with a one-cycle `eng_rst` pulse. On the first attempt, `eng_req` rises in the cycle after the pulse ends. On every later attempt, `eng_req` rises no earlier than `BACKOFF_US` microseconds after the pulse ends.
- R8: `eng_req` stays high until `eng_done` arrives. If `eng_done` does not arrive within `XFER_US` microseconds, the block finishes with code 4 (I/O error) and makes no further attempt.
- R9: A reply code of 4'h8 or 4'h2 is a defer. With `cmd_retry` set, a defer starts another attempt. With `cmd_retry` clear, or with any other reply code, the command finishes with code 0 and `res_reply` equal to the reply.
- R10: A nonzero `eng_err` gives code 4. Otherwise a set `eng_tmo` gives code 3. Both outrank a defer, and neither starts another attempt.
- R11: At most `MAX_TRIES` attempts are made. If the last permitted attempt still defers, the block finishes with code 0 and that defer code in `res_reply`.
- R12: For a read-type command whose final attempt received `eng_done`, `res_rdata` holds the `eng_rdata` from that attempt. In every other case `res_rdata` is 0.
- R13: `done` lasts exactly one cycle and `res_code` is valid with it. `own_req` is 2'b00 while `done` is high. `res_reply` is 0 unless `res_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle; the command is taken on valid and ready |
| cmd_type | input | 4 | Request type; bit 0 set means read |
| cmd_addr | input | ADDR_W | Transfer address |
| cmd_len | input | LEN_W | Byte count, 1 to MAX_BYTES |
| cmd_wdata | input | BUF_W | Write bytes, byte k at bits 8k+7:8k |
| cmd_retry | input | 1 | Permit repeats on a defer reply |
| done | output | 1 | One-cycle completion pulse |
| res_code | output | 3 | 0 ok, 1 busy, 2 no device, 3 timeout, 4 I/O error |
| res_reply | output | 4 | Reply code when the result is ok |
| res_rdata | output | BUF_W | Receive buffer for read commands |
| eng_rst | output | 1 | Engine reset pulse |
| eng_req | output | 1 | Transfer request, held until the engine completes |
| eng_cmd | output | 32 | Command word for the engine |
| eng_addr | output | ADDR_W | Address for the engine |
| eng_wdata | output | BUF_W | Transmit buffer |
| own_req | output | 2 | Channel ownership request |
| own_ack | input | 2 | Ownership acknowledge pattern |
| eng_busy | input | 1 | Engine still busy with earlier work |
| eng_sink | input | 1 | Sink attached |
| eng_done | input | 1 | Engine finished the transfer (one cycle) |
| eng_reply | input | 4 | Reply code, valid with eng_done |
| eng_tmo | input | 1 | Reply timeout flag, valid with eng_done |
| eng_err | input | 3 | Error field, valid with eng_done |
| eng_rdata | input | BUF_W | Receive bytes, valid with eng_done |

## Verification
A wrong state or a wrong attempt count does not stay hidden. It shows at the engine pins within a cycle, either as an extra or missing `eng_rst` pulse or as an `eng_req` that rises too soon after that pulse. It also shows within a few cycles in the `res_code` that arrives with `done`. A wrong timer limit or a stuck divider instead shows as an early or late `done`, bounded by the microsecond intervals. A corrupted capture register shows as a wrong `eng_cmd`, `eng_wdata` or `res_rdata` word on the same command. Sweeps over every reply code, every error and timeout combination, and every type and length pair make each of these visible.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;

  typedef enum logic [2:0] {
    RES_OK    = 3'd0,
    RES_BUSY  = 3'd1,
    RES_NODEV = 3'd2,
    RES_TMO   = 3'd3,
    RES_IO    = 3'd4
  } aux_res_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_IDLE,
    ST_OWN,
    ST_SINK,
    ST_RST_HI,
    ST_RST_LO,
    ST_BACKOFF,
    ST_REQ,
    ST_DONE
  } aux_st_e;

  typedef enum logic [1:0] {
    VERD_DONE,
    VERD_RETRY,
    VERD_TMO,
    VERD_IO
  } aux_verdict_e;

  localparam logic [3:0] REPLY_DEFER_A = 4'h8;
  localparam logic [3:0] REPLY_DEFER_B = 4'h2;

endpackage

// File: rtl/aux_us_tick.sv
// Microsecond strobe from a clock divider; restarts whenever clr is high.
module aux_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DIV_W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;

  logic [DIV_W-1:0] div_q;

  assign tick = ~clr && (div_q == DIV_W'(CLK_PER_US - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (clr || tick) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/aux_us_count.sv
// Saturating microsecond counter compared against a per-state limit.
module aux_us_count #(
  parameter int UW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic [UW-1:0] limit,
  output logic          expired
);
  logic [UW-1:0] us_q;

  assign expired = (us_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_q <= '0;
    end else if (clr) begin
      us_q <= '0;
    end else if (tick && !expired) begin
      us_q <= us_q + UW'(1);
    end
  end
endmodule

// File: rtl/aux_reply_class.sv
// Sorts one finished attempt: error outranks timeout, timeout outranks defer.
module aux_reply_class
  import aux_seq_pkg::*;
(
  input  logic         [3:0] reply,
  input  logic               tmo,
  input  logic         [2:0] err,
  input  logic               retry_en,
  input  logic               last_try,
  output aux_verdict_e       verdict
);
  logic is_defer;

  assign is_defer = (reply == REPLY_DEFER_A) || (reply == REPLY_DEFER_B);

  always_comb begin
    if (|err) begin
      verdict = VERD_IO;
    end else if (tmo) begin
      verdict = VERD_TMO;
    end else if (is_defer && retry_en && !last_try) begin
      verdict = VERD_RETRY;
    end else begin
      verdict = VERD_DONE;
    end
  end
endmodule

// File: rtl/aux_wbuf_mask.sv
// Keeps the first len bytes of the write data and clears the rest.
module aux_wbuf_mask #(
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 5
) (
  input  logic [MAX_BYTES*8-1:0] din,
  input  logic [LEN_W-1:0]       len,
  output logic [MAX_BYTES*8-1:0] dout
);
  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = (LEN_W'(b) < len) ? din[8*b +: 8] : 8'h00;
  end
endmodule

// File: rtl/aux_retry_seq.sv
module aux_retry_seq
  import aux_seq_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int IDLE_US    = 1000,
  parameter int OWN_US     = 1000,
  parameter int XFER_US    = 1000,
  parameter int BACKOFF_US = 400,
  parameter int MAX_TRIES  = 32,
  parameter int MAX_BYTES  = 16,
  parameter int ADDR_W     = 20,
  parameter int OWN_SEL    = 0,
  localparam int LEN_W     = $clog2(MAX_BYTES + 1),
  localparam int BUF_W     = MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [BUF_W-1:0]  cmd_wdata,
  input  logic              cmd_retry,
  output logic              done,
  output logic [2:0]        res_code,
  output logic [3:0]        res_reply,
  output logic [BUF_W-1:0]  res_rdata,
  output logic              eng_rst,
  output logic              eng_req,
  output logic [31:0]       eng_cmd,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [BUF_W-1:0]  eng_wdata,
  output logic [1:0]        own_req,
  input  logic [1:0]        own_ack,
  input  logic              eng_busy,
  input  logic              eng_sink,
  input  logic              eng_done,
  input  logic [3:0]        eng_reply,
  input  logic              eng_tmo,
  input  logic [2:0]        eng_err,
  input  logic [BUF_W-1:0]  eng_rdata
);
  localparam int LIM_A   = (IDLE_US > OWN_US) ? IDLE_US : OWN_US;
  localparam int LIM_B   = (XFER_US > BACKOFF_US) ? XFER_US : BACKOFF_US;
  localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int UW      = $clog2(LIM_MAX + 2);
  localparam int TRY_W   = $clog2(MAX_TRIES + 1);
  localparam logic [1:0] OWN_BIT = 2'(1 << OWN_SEL);

  aux_st_e            state, nxt;
  aux_res_e           fin_code, res_code_q;
  aux_verdict_e       verdict;

  logic [3:0]         type_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [LEN_W-1:0]   len_q;
  logic [BUF_W-1:0]   wdata_q;
  logic               retry_q;
  logic [TRY_W-1:0]   tries_q;
  logic [3:0]         reply_q;
  logic [BUF_W-1:0]   rdata_q;
  logic [31:0]        cmd_q;
  logic [ADDR_W-1:0]  eaddr_q;
  logic [BUF_W-1:0]   ewdata_q;
  logic [1:0]         own_q;

  logic               tmr_clr, us_tick, expired, last_try, idle_ok;
  logic [UW-1:0]      limit;
  logic [BUF_W-1:0]   wdata_masked;
  logic [31:0]        cmd_word;

  // ---------------------------------------------------------------------------
  // Interval timing
  // ---------------------------------------------------------------------------
  assign tmr_clr = (nxt != state);

  always_comb begin
    case (state)
      ST_WAIT_IDLE: limit = UW'(IDLE_US);
      ST_OWN:       limit = UW'(OWN_US);
      ST_BACKOFF:   limit = UW'(BACKOFF_US);
      default:      limit = UW'(XFER_US);
    endcase
  end

  aux_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (us_tick)
  );

  aux_us_count #(.UW(UW)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .tick    (us_tick),
    .limit   (limit),
    .expired (expired)
  );

  // ---------------------------------------------------------------------------
  // Reply sorting and buffer shaping
  // ---------------------------------------------------------------------------
  assign last_try = (tries_q >= TRY_W'(MAX_TRIES - 1));

  aux_reply_class u_class (
    .reply    (eng_reply),
    .tmo      (eng_tmo),
    .err      (eng_err),
    .retry_en (retry_q),
    .last_try (last_try),
    .verdict  (verdict)
  );

  aux_wbuf_mask #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W)) u_mask (
    .din  (wdata_q),
    .len  (len_q),
    .dout (wdata_masked)
  );

  always_comb begin
    cmd_word        = '0;
    cmd_word[15:12] = type_q;
    cmd_word[7:0]   = 8'(len_q) - 8'd1;
  end

  assign idle_ok = !eng_busy && (own_ack == 2'b00);

  // ---------------------------------------------------------------------------
  // Sequencing
  // ---------------------------------------------------------------------------
  always_comb begin
    nxt      = state;
    fin_code = RES_OK;
    case (state)
      ST_IDLE: begin
        if (cmd_valid) nxt = ST_WAIT_IDLE;
      end
      ST_WAIT_IDLE: begin
        if (idle_ok) begin
          nxt = ST_OWN;
        end else if (expired) begin
          nxt      = ST_DONE;
          fin_code = RES_BUSY;
        end
      end
      ST_OWN: begin
        if (own_ack == OWN_BIT) begin
          nxt = ST_SINK;
        end else if (expired) begin
          nxt      = ST_DONE;
          fin_code = RES_BUSY;
        end
      end
      ST_SINK: begin
        if (eng_sink) begin
          nxt = ST_RST_HI;
        end else begin
          nxt      = ST_DONE;
          fin_code = RES_NODEV;
        end
      end
      ST_RST_HI: nxt = ST_RST_LO;
      ST_RST_LO: nxt = (tries_q == '0) ? ST_REQ : ST_BACKOFF;
      ST_BACKOFF: begin
        if (expired) nxt = ST_REQ;
      end
      ST_REQ: begin
        if (eng_done) begin
          case (verdict)
            VERD_RETRY: nxt = ST_RST_HI;
            VERD_TMO: begin
              nxt      = ST_DONE;
              fin_code = RES_TMO;
            end
            VERD_IO: begin
              nxt      = ST_DONE;
              fin_code = RES_IO;
            end
            default: begin
              nxt      = ST_DONE;
              fin_code = RES_OK;
            end
          endcase
        end else if (expired) begin
          nxt      = ST_DONE;
          fin_code = RES_IO;
        end
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      type_q     <= '0;
      addr_q     <= '0;
      len_q      <= '0;
      wdata_q    <= '0;
      retry_q    <= 1'b0;
      tries_q    <= '0;
      reply_q    <= '0;
      rdata_q    <= '0;
      cmd_q      <= '0;
      eaddr_q    <= '0;
      ewdata_q   <= '0;
      own_q      <= '0;
      res_code_q <= RES_OK;
    end else begin
      state <= nxt;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            type_q  <= cmd_type;
            addr_q  <= cmd_addr;
            len_q   <= cmd_len;
            wdata_q <= cmd_wdata;
            retry_q <= cmd_retry;
            reply_q <= '0;
            rdata_q <= '0;
          end
        end
        ST_WAIT_IDLE: begin
          if (idle_ok) own_q <= OWN_BIT;
        end
        ST_SINK: begin
          if (eng_sink) begin
            cmd_q   <= cmd_word;
            eaddr_q <= addr_q;
            tries_q <= '0;
            if (!type_q[0]) ewdata_q <= wdata_masked;
          end
        end
        ST_REQ: begin
          if (eng_done) begin
            tries_q <= tries_q + TRY_W'(1);
            if (type_q[0] && (verdict != VERD_RETRY)) rdata_q <= eng_rdata;
            if (verdict == VERD_DONE) reply_q <= eng_reply;
          end
        end
        default: ;
      endcase
      if (nxt == ST_DONE) begin
        own_q      <= '0;
        res_code_q <= fin_code;
      end
    end
  end

  assign cmd_ready = (state == ST_IDLE);
  assign done      = (state == ST_DONE);
  assign eng_rst   = (state == ST_RST_HI);
  assign eng_req   = (state == ST_REQ);
  assign own_req   = own_q;
  assign eng_cmd   = cmd_q;
  assign eng_addr  = eaddr_q;
  assign eng_wdata = ewdata_q;
  assign res_code  = res_code_q;
  assign res_reply = reply_q;
  assign res_rdata = rdata_q;

endmodule

// File: rtl/aux_retry_seq_chk.sv
module aux_retry_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_ready,
  input logic       done,
  input logic [2:0] res_code,
  input logic [1:0] own_req,
  input logic       eng_rst,
  input logic       eng_req,
  input logic       eng_done
);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R13
  own_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (own_req == 2'b00));

  // R3
  req_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> ($countones(own_req) == 1));

  // R7
  rst_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst |-> ($countones(own_req) == 1));

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req || done));

  // R1
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!eng_req && !eng_rst && (own_req == 2'b00)));

  // R13
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_code <= 3'd4));
endmodule

bind aux_retry_seq aux_retry_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .done      (done),
  .res_code  (res_code),
  .own_req   (own_req),
  .eng_rst   (eng_rst),
  .eng_req   (eng_req),
  .eng_done  (eng_done)
);

// File: tb/aux_retry_seq_bench.sv
module aux_retry_seq_bench;
  localparam int CPU   = 2;
  localparam int IDLE  = 4;
  localparam int OWNL  = 4;
  localparam int XFER  = 6;
  localparam int BO    = 3;
  localparam int TRIES = 5;
  localparam int SEL   = 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid, cmd_ready, cmd_retry, done;
  logic [3:0]   cmd_type;
  logic [19:0]  cmd_addr;
  logic [4:0]   cmd_len;
  logic [127:0] cmd_wdata, res_rdata, eng_wdata, eng_rdata;
  logic [2:0]   res_code;
  logic [3:0]   res_reply;
  logic         eng_rst, eng_req;
  logic [31:0]  eng_cmd;
  logic [19:0]  eng_addr;
  logic [1:0]   own_req, own_ack;
  logic         eng_busy, eng_sink, eng_done, eng_tmo;
  logic [3:0]   eng_reply;
  logic [2:0]   eng_err;

  always #10 clk = ~clk;

  aux_retry_seq #(
    .CLK_PER_US(CPU), .IDLE_US(IDLE), .OWN_US(OWNL), .XFER_US(XFER),
    .BACKOFF_US(BO), .MAX_TRIES(TRIES), .MAX_BYTES(16), .ADDR_W(20), .OWN_SEL(SEL)
  ) u_aux_retry_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
    .cmd_retry(cmd_retry), .done(done), .res_code(res_code), .res_reply(res_reply),
    .res_rdata(res_rdata), .eng_rst(eng_rst), .eng_req(eng_req), .eng_cmd(eng_cmd),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .own_req(own_req), .own_ack(own_ack),
    .eng_busy(eng_busy), .eng_sink(eng_sink), .eng_done(eng_done), .eng_reply(eng_reply),
    .eng_tmo(eng_tmo), .eng_err(eng_err), .eng_rdata(eng_rdata)
  );

  // Engine model controls
  int           m_ack_mode, m_delay, m_defer_n, att_idx, req_age;
  bit           m_respond, m_tmo;
  logic [3:0]   m_defer_code, m_final;
  logic [2:0]   m_err;

  // Monitor state
  int  n_checks = 0, n_fail = 0, cyc = 0, att_cnt, fall_cyc, first_gap, min_gap;
  bit  own_seen, req_seen, prev_rst, prev_req;

  // Captured results
  logic [2:0]   r_code;
  logic [3:0]   r_reply;
  logic [127:0] r_rdata;
  logic [1:0]   r_own;
  bit           r_rdy_mid;

  always @(posedge clk) begin
    if (m_ack_mode == 1)      own_ack <= own_req;
    else if (m_ack_mode == 2) own_ack <= {own_req[0], own_req[1]};
    else                      own_ack <= 2'b00;
    if (eng_req) begin
      if (m_respond && req_age == m_delay) begin
        eng_done  <= 1'b1;
        eng_reply <= (att_idx < m_defer_n) ? m_defer_code : m_final;
        eng_tmo   <= m_tmo;
        eng_err   <= m_err;
        att_idx   <= att_idx + 1;
      end else begin
        eng_done <= 1'b0;
      end
      req_age <= req_age + 1;
    end else begin
      req_age  <= 0;
      eng_done <= 1'b0;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (eng_rst && !prev_rst) att_cnt++;
    if (!eng_rst && prev_rst) fall_cyc = cyc;
    if (eng_req && !prev_req) begin
      if (att_cnt == 1) first_gap = cyc - fall_cyc;
      else if (cyc - fall_cyc < min_gap) min_gap = cyc - fall_cyc;
    end
    if (|own_req) own_seen = 1'b1;
    if (eng_req) req_seen = 1'b1;
    prev_rst = eng_rst;
    prev_req = eng_req;
  end

  task automatic summary_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  always @(negedge clk) begin
    if (cyc > 190000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: global cycle limit actual=%0d expected<190000", cyc);
      summary_and_end();
    end
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mask_bytes(input logic [127:0] w, input int l);
    logic [127:0] r = '0;
    for (int b = 0; b < 16; b++) if (b < l) r[8*b +: 8] = w[8*b +: 8];
    return r;
  endfunction

  task automatic run_cmd(input logic [3:0] t, input int l, input logic [19:0] a,
                         input logic [127:0] w, input bit rt);
    int n;
    @(negedge clk);
    att_cnt = 0; att_idx = 0; own_seen = 0; req_seen = 0;
    first_gap = -1; min_gap = 1000000;
    cmd_type = t; cmd_len = 5'(l); cmd_addr = a; cmd_wdata = w; cmd_retry = rt;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    r_rdy_mid = cmd_ready;
    n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: no done actual=0 expected=1");
      summary_and_end();
    end
    r_code = res_code; r_reply = res_reply; r_rdata = res_rdata; r_own = own_req;
  endtask

  logic [127:0] exp_wbuf, w;
  logic [31:0]  exp_cmd;
  logic [19:0]  a;
  int           exp_att;
  logic [2:0]   exp_code;

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_type = '0; cmd_addr = '0; cmd_len = 5'd1;
    cmd_wdata = '0; cmd_retry = 1'b0;
    own_ack = '0; eng_done = 1'b0; eng_reply = '0; eng_tmo = 1'b0; eng_err = '0;
    eng_busy = 1'b0; eng_sink = 1'b1; eng_rdata = '0;
    m_ack_mode = 1; m_delay = 2; m_defer_n = 0; m_respond = 1'b1; m_tmo = 1'b0;
    m_defer_code = 4'h8; m_final = 4'h0; m_err = '0; att_idx = 0; req_age = 0;
    att_cnt = 0; fall_cyc = 0; prev_rst = 0; prev_req = 0; exp_wbuf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(cmd_ready == 1'b1, "R1 ready after reset", 128'(cmd_ready), 128'd1);
    check({done, eng_req, eng_rst} == 3'b000, "R1 outputs quiet after reset",
          128'({done, eng_req, eng_rst}), 128'd0);
    check(own_req == 2'b00, "R1 own_req after reset", 128'(own_req), 128'd0);

    // R2 engine never idle
    eng_busy = 1'b1;
    run_cmd(4'h0, 2, 20'h1, 128'h1234, 1'b1);
    check(r_code == 3'd1, "R2 busy code", 128'(r_code), 128'd1);
    check(own_seen == 1'b0, "R2 no ownership request", 128'(own_seen), 128'd0);
    check(r_rdy_mid == 1'b0, "R1 ready low while working", 128'(r_rdy_mid), 128'd0);
    eng_busy = 1'b0;

    // R3 no acknowledge, then wrong acknowledge bit
    for (int md = 0; md <= 2; md += 2) begin
      m_ack_mode = md;
      run_cmd(4'h0, 2, 20'h2, 128'h55, 1'b1);
      check(r_code == 3'd1, "R3 ownership timeout code", 128'(r_code), 128'd1);
      check(own_seen == 1'b1, "R3 ownership requested", 128'(own_seen), 128'd1);
      check(att_cnt == 0, "R3 no attempt", 128'(att_cnt), 128'd0);
      check(r_own == 2'b00, "R13 ownership released at done", 128'(r_own), 128'd0);
    end
    m_ack_mode = 1;

    // R4 sink absent
    eng_sink = 1'b0;
    run_cmd(4'h1, 4, 20'h3, 128'h0, 1'b1);
    check(r_code == 3'd2, "R4 no device code", 128'(r_code), 128'd2);
    check(req_seen == 1'b0, "R4 no request issued", 128'(req_seen), 128'd0);
    eng_sink = 1'b1;

    // R5 R6 R12 sweep over every type and length
    for (int t = 0; t < 16; t++) begin
      for (int l = 1; l <= 16; l++) begin
        a = 20'((t << 12) ^ (l * 20'h111) ^ 20'h5a5a5);
        w = {4{32'hC3A5_0F00 ^ 32'(t * 37 + l * 101)}} ^ (128'(l) << (8 * (l - 1)));
        eng_rdata = ~w;
        run_cmd(4'(t), l, a, w, 1'b1);
        if (t % 2 == 0) exp_wbuf = mask_bytes(w, l);
        exp_cmd = (32'(t) << 12) | 32'(l - 1);
        check(r_code == 3'd0 && r_reply == 4'h0, "R9 plain ack completes",
              128'({r_code, r_reply}), 128'd0);
        check(eng_cmd == exp_cmd, "R6 command word", 128'(eng_cmd), 128'(exp_cmd));
        check(eng_addr == a, "R6 address", 128'(eng_addr), 128'(a));
        check(eng_wdata == exp_wbuf, "R5 transmit buffer", eng_wdata, exp_wbuf);
        check(r_rdata == ((t % 2 == 1) ? ~w : 128'd0), "R12 receive buffer",
              r_rdata, (t % 2 == 1) ? ~w : 128'd0);
      end
    end

    // R9 R11 R7 sweep over every reply code with and without repeats
    eng_rdata = 128'hFEED_0000_BEEF;
    for (int c = 0; c < 16; c++) begin
      for (int rt = 0; rt < 2; rt++) begin
        m_final = 4'(c);
        run_cmd(4'h9, 4, 20'h77, 128'h0, rt[0]);
        exp_att = ((c == 8 || c == 2) && rt == 1) ? TRIES : 1;
        check(att_cnt == exp_att, "R11 attempt count", 128'(att_cnt), 128'(exp_att));
        check(r_code == 3'd0 && r_reply == 4'(c), "R9 reply returned",
              128'({r_code, r_reply}), 128'(c));
        check(first_gap == 1, "R7 first request follows reset", 128'(first_gap), 128'd1);
        if (exp_att > 1)
          check(min_gap >= BO * CPU, "R7 back-off before repeat", 128'(min_gap),
                128'(BO * CPU));
        check(eng_wdata == exp_wbuf, "R5 read leaves transmit buffer", eng_wdata, exp_wbuf);
      end
    end

    // R11 defers followed by a final reply
    m_final = 4'h5;
    for (int k = 1; k < TRIES; k++) begin
      m_defer_n = k;
      m_defer_code = (k % 2 == 1) ? 4'h2 : 4'h8;
      run_cmd(4'h0, 1, 20'h9, 128'hAB, 1'b1);
      check(att_cnt == k + 1, "R11 stops at first non-defer", 128'(att_cnt), 128'(k + 1));
      check(r_reply == 4'h5, "R9 final reply", 128'(r_reply), 128'h5);
    end
    m_defer_n = 0;

    // R10 error and timeout priority over a defer
    m_final = 4'h8;
    for (int e = 0; e < 8; e++) begin
      for (int tm = 0; tm < 2; tm++) begin
        m_err = 3'(e); m_tmo = tm[0];
        eng_rdata = 128'(e * 16 + tm + 1);
        run_cmd(4'h1, 8, 20'h44, 128'h0, 1'b1);
        exp_code = (e != 0) ? 3'd4 : (tm != 0) ? 3'd3 : 3'd0;
        exp_att = (exp_code == 3'd0) ? TRIES : 1;
        check(r_code == exp_code, "R10 priority code", 128'(r_code), 128'(exp_code));
        check(att_cnt == exp_att, "R10 attempts", 128'(att_cnt), 128'(exp_att));
        check(r_reply == ((exp_code == 3'd0) ? 4'h8 : 4'h0), "R13 reply only on ok",
              128'(r_reply), (exp_code == 3'd0) ? 128'h8 : 128'h0);
        check(r_rdata == 128'(e * 16 + tm + 1), "R12 final receive buffer", r_rdata,
              128'(e * 16 + tm + 1));
      end
    end
    m_err = '0; m_tmo = 1'b0; m_final = 4'h0;

    // R8 engine never completes
    m_respond = 1'b0;
    run_cmd(4'h1, 3, 20'h6, 128'h0, 1'b1);
    check(r_code == 3'd4, "R8 transfer timeout code", 128'(r_code), 128'd4);
    check(att_cnt == 1, "R8 single attempt", 128'(att_cnt), 128'd1);
    check(r_rdata == 128'd0, "R12 no receive data without reply", r_rdata, 128'd0);
    m_respond = 1'b1;

    summary_and_end();
  end
endmodule